// File: doc/BRIEF.md
# Interleaving Stream Arbiter with 64-Byte Switch Granularity

This block merges several AXI4-Stream sources into a single output stream whose data path is 128, 256 or 512 bits wide. Each source brings its own 6-bit stream identifier and 10-bit routing destination. Both are carried to the output along with the byte-enable mask (TKEEP) and the end-of-packet flag. There is no TSTRB port.

Beats from different sources may be interleaved on the output, but only at chosen points. The arbiter may move its grant away from a source after that source has sent a nonzero whole multiple of 64 bytes since its last switch point. It may also move after a beat that carries TLAST. Bytes are counted as the number of set TKEEP bits on accepted beats. At a switch point the next source is chosen by round robin among the sources that are presenting data. If the current source is the only one requesting, it keeps the grant.

If the granted source has not had a beat accepted since the last switch point and is not presenting data, the grant may pass to another requester. This keeps one idle source from blocking the others. The output sees no bubble when the grant moves at a switch point.

Top module: `axis_ilv_arb`

## Requirements
- R1: After a synchronous reset the grant rests on source 0 and the byte tally is empty. With the output ready high, only bit 0 of `s_tready` is set.
- R2: `m_tvalid`, `m_tdata`, `m_tkeep`, `m_tlast`, `m_tid` and `m_tdest` always mirror the currently granted source.
- R3: `s_tready` has at most one bit set, the bit of the granted source, and that bit equals `m_tready`. While `m_tready` is low no source is ready.
- R4: The grant does not move after an accepted beat that is not a switch point. It also does not move while the granted source is silent partway through a chunk, or while the output is stalled with valid data.
- R5: The byte tally adds the popcount of TKEEP on each accepted beat, so an all-zero TKEEP adds nothing. A switch point occurs on the accepted beat that adds a nonzero count and brings the tally to a multiple of 64.
- R6: Every accepted beat with TLAST high is a switch point, whatever the byte tally.
- R7: At a switch point the grant moves to the first source with TVALID high, searching upward from the current index + 1 with wrap-around. The current source is considered last, so it keeps the grant when no other source is requesting.
- R8: The byte tally is cleared at every switch point, including when the grant stays on the same source.
- R9: When no beat has been accepted since the last switch point and the granted source has TVALID low, the grant moves on the next clock edge to the round-robin choice among the requesting sources.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tvalid | input | N | Per-source valid |
| s_tready | output | N | Per-source ready |
| s_tdata | input | N*DW | Per-source data, source i in bits [i*DW +: DW] |
| s_tkeep | input | N*DW/8 | Per-source byte-enable mask |
| s_tlast | input | N | Per-source end-of-packet flag |
| s_tid | input | N*6 | Per-source stream identifier |
| s_tdest | input | N*10 | Per-source routing destination |
| m_tvalid | output | 1 | Output valid |
| m_tready | input | 1 | Output ready |
| m_tdata | output | DW | Output data |
| m_tkeep | output | DW/8 | Output byte-enable mask |
| m_tlast | output | 1 | Output end-of-packet flag |
| m_tid | output | 6 | Output stream identifier |
| m_tdest | output | 10 | Output routing destination |

## Verification
On every cycle, the assertions check four things. The ready vector must be one-hot-or-zero and tied to the output ready. The grant must stay fixed across stalled and mid-chunk beats. A TLAST beat must always be a switch point, and the tally must be empty after it. Any change of grant must follow either a switch-point beat or an idle, untouched grant. Which source wins after a switch point, and the exact count at which a 64-byte boundary falls, can only be shown by the bench's scenarios. These cover mixed TKEEP widths, all-zero TKEEP beats, a grant held on a lone requester with its tally restarted, wrap-around of the round-robin order, and a reset in the middle of a chunk.

// File: rtl/axis_ilv_pkg.sv
package axis_ilv_pkg;

    localparam int TID_W       = 6;
    localparam int TDEST_W     = 10;
    localparam int CHUNK_BYTES = 64;
    localparam int CHUNK_W     = $clog2(CHUNK_BYTES);

    // Sideband that travels with every beat
    typedef struct packed {
        logic               last;
        logic [TID_W-1:0]   tid;
        logic [TDEST_W-1:0] tdest;
    } side_t;

    // Whether the current grant has had a beat accepted since its last switch point
    typedef enum logic {
        ST_FRESH = 1'b0,
        ST_MID   = 1'b1
    } tally_st_t;

    function automatic bit width_ok(int dw);
        return (dw == 128) || (dw == 256) || (dw == 512);
    endfunction

endpackage

// File: rtl/axis_ilv_pick.sv
module axis_ilv_pick #(
    parameter  int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] cur,
    output logic [IW-1:0] nxt,
    output logic          found
);
    int idx;

    // Search cur+1, cur+2, ... wrapping, with cur itself last.
    // Walk from the far end so the nearest requester is written last.
    always_comb begin
        found = 1'b0;
        nxt   = cur;
        idx   = 0;
        for (int k = N; k >= 1; k--) begin
            idx = (int'(cur) + k) % N;
            if (req[idx]) begin
                found = 1'b1;
                nxt   = IW'(idx);
            end
        end
    end

endmodule

// File: rtl/axis_ilv_tally.sv
module axis_ilv_tally
    import axis_ilv_pkg::*;
#(
    parameter  int KW = 16,
    localparam int PW = $clog2(KW + 1),
    localparam int SW = ((PW > CHUNK_W) ? PW : CHUNK_W) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic [KW-1:0] keep,
    input  logic          last,
    output logic          switch_pt,
    output logic          fresh
);
    logic [CHUNK_W-1:0] rem_q;
    tally_st_t          st_q;
    logic [PW-1:0]      pop;
    logic [SW-1:0]      sum;
    logic               chunk_done;

    always_comb begin
        pop = '0;
        for (int b = 0; b < KW; b++) begin
            pop = pop + PW'(keep[b]);
        end
    end

    assign sum        = SW'(rem_q) + SW'(pop);
    assign chunk_done = (pop != '0) && (sum[CHUNK_W-1:0] == '0);
    assign switch_pt  = fire && (last || chunk_done);
    assign fresh      = (st_q == ST_FRESH);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            st_q  <= ST_FRESH;
        end else if (fire) begin
            if (switch_pt) begin
                rem_q <= '0;
                st_q  <= ST_FRESH;
            end else begin
                rem_q <= sum[CHUNK_W-1:0];
                st_q  <= ST_MID;
            end
        end
    end

endmodule

// File: rtl/axis_ilv_mux.sv
module axis_ilv_mux
    import axis_ilv_pkg::*;
#(
    parameter  int N  = 4,
    parameter  int DW = 128,
    localparam int KW = DW / 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [IW-1:0]        sel,
    input  logic [N-1:0]         s_tvalid,
    output logic [N-1:0]         s_tready,
    input  logic [N*DW-1:0]      s_tdata,
    input  logic [N*KW-1:0]      s_tkeep,
    input  logic [N-1:0]         s_tlast,
    input  logic [N*TID_W-1:0]   s_tid,
    input  logic [N*TDEST_W-1:0] s_tdest,
    output logic                 m_tvalid,
    input  logic                 m_tready,
    output logic [DW-1:0]        m_tdata,
    output logic [KW-1:0]        m_tkeep,
    output side_t                m_side
);
    logic [DW-1:0] dat  [N];
    logic [KW-1:0] kp   [N];
    side_t         side [N];

    for (genvar g = 0; g < N; g++) begin : g_src
        assign dat[g]        = s_tdata[g*DW +: DW];
        assign kp[g]         = s_tkeep[g*KW +: KW];
        assign side[g].last  = s_tlast[g];
        assign side[g].tid   = s_tid[g*TID_W +: TID_W];
        assign side[g].tdest = s_tdest[g*TDEST_W +: TDEST_W];
        assign s_tready[g]   = m_tready && (sel == IW'(g));
    end

    assign m_tvalid = s_tvalid[sel];
    assign m_tdata  = dat[sel];
    assign m_tkeep  = kp[sel];
    assign m_side   = side[sel];

endmodule

// File: rtl/axis_ilv_arb.sv
module axis_ilv_arb
    import axis_ilv_pkg::*;
#(
    parameter  int N  = 4,
    parameter  int DW = 128,
    localparam int KW = DW / 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         s_tvalid,
    output logic [N-1:0]         s_tready,
    input  logic [N*DW-1:0]      s_tdata,
    input  logic [N*KW-1:0]      s_tkeep,
    input  logic [N-1:0]         s_tlast,
    input  logic [N*TID_W-1:0]   s_tid,
    input  logic [N*TDEST_W-1:0] s_tdest,
    output logic                 m_tvalid,
    input  logic                 m_tready,
    output logic [DW-1:0]        m_tdata,
    output logic [KW-1:0]        m_tkeep,
    output logic                 m_tlast,
    output logic [TID_W-1:0]     m_tid,
    output logic [TDEST_W-1:0]   m_tdest
);
    if (!width_ok(DW)) begin : g_bad_width
        $error("axis_ilv_arb: DW must be 128, 256 or 512");
    end

    logic [IW-1:0] grant_q;
    logic [IW-1:0] nxt;
    logic          found;
    logic          fire;
    logic          switch_pt;
    logic          fresh;
    logic          idle_move;
    side_t         m_side;

    axis_ilv_mux #(.N(N), .DW(DW)) u_mux (
        .sel      (grant_q),
        .s_tvalid (s_tvalid),
        .s_tready (s_tready),
        .s_tdata  (s_tdata),
        .s_tkeep  (s_tkeep),
        .s_tlast  (s_tlast),
        .s_tid    (s_tid),
        .s_tdest  (s_tdest),
        .m_tvalid (m_tvalid),
        .m_tready (m_tready),
        .m_tdata  (m_tdata),
        .m_tkeep  (m_tkeep),
        .m_side   (m_side)
    );

    assign m_tlast = m_side.last;
    assign m_tid   = m_side.tid;
    assign m_tdest = m_side.tdest;
    assign fire    = m_tvalid && m_tready;

    axis_ilv_pick #(.N(N)) u_pick (
        .req   (s_tvalid),
        .cur   (grant_q),
        .nxt   (nxt),
        .found (found)
    );

    axis_ilv_tally #(.KW(KW)) u_tally (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .keep      (m_tkeep),
        .last      (m_tlast),
        .switch_pt (switch_pt),
        .fresh     (fresh)
    );

    // An untouched grant whose source is silent may hand over without a beat
    assign idle_move = fresh && !m_tvalid && found;

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
        end else if ((switch_pt && found) || idle_move) begin
            grant_q <= nxt;
        end
    end

endmodule

// File: rtl/axis_ilv_arb_chk.sv
module axis_ilv_arb_chk #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic [N-1:0]  s_tready,
    input logic          m_tvalid,
    input logic          m_tready,
    input logic          m_tlast,
    input logic [IW-1:0] grant,
    input logic          switch_pt,
    input logic          fresh
);
    logic xfer;
    assign xfer = m_tvalid && m_tready;

    a_r3_ready_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(s_tready) && ((|s_tready) == m_tready));

    a_r4_hold_midchunk: assert property (@(posedge clk) disable iff (rst)
        (xfer && !switch_pt) |=> $stable(grant));

    a_r4_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> $stable(grant));

    a_r6_last_switches: assert property (@(posedge clk) disable iff (rst)
        (xfer && m_tlast) |-> switch_pt);

    a_r8_tally_cleared: assert property (@(posedge clk) disable iff (rst)
        (xfer && switch_pt) |=> fresh);

    a_r9_move_legal: assert property (@(posedge clk) disable iff (rst)
        !$stable(grant) |-> ($past(xfer && switch_pt) || $past(fresh && !m_tvalid)));

endmodule

bind axis_ilv_arb axis_ilv_arb_chk #(.N(N), .IW(IW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .s_tready  (s_tready),
    .m_tvalid  (m_tvalid),
    .m_tready  (m_tready),
    .m_tlast   (m_tlast),
    .grant     (grant_q),
    .switch_pt (switch_pt),
    .fresh     (fresh)
);

// File: tb/tb_axis_ilv_arb.sv
module tb_axis_ilv_arb;
    localparam int N  = 4;
    localparam int DW = 128;
    localparam int KW = DW / 8;
    localparam int NV = 24;

    // Entry: {valid[3:0], last[3:0], bytes[4:0], ready, expected_src[1:0]}
    localparam logic [15:0] VEC [NV] = '{
        {4'b0001, 4'b0000, 5'd16, 1'b1, 2'd0},  // 1  R2 R5 tally 16
        {4'b0011, 4'b0000, 5'd16, 1'b1, 2'd0},  // 2  R4 tally 32
        {4'b0010, 4'b0000, 5'd16, 1'b1, 2'd0},  // 3  R4 silent mid-chunk
        {4'b0011, 4'b0000, 5'd16, 1'b0, 2'd0},  // 4  R3 stall
        {4'b0011, 4'b0000, 5'd16, 1'b1, 2'd0},  // 5  R5 tally 48
        {4'b0011, 4'b0000, 5'd16, 1'b1, 2'd0},  // 6  R5 tally 64 -> src1
        {4'b0111, 4'b0000, 5'd8,  1'b1, 2'd1},  // 7  R7 tally 8
        {4'b0111, 4'b0010, 5'd8,  1'b1, 2'd1},  // 8  R6 last -> src2
        {4'b0100, 4'b0100, 5'd16, 1'b1, 2'd2},  // 9  R7 lone requester holds
        {4'b0100, 4'b0000, 5'd16, 1'b1, 2'd2},  // 10 R8 tally 16
        {4'b0100, 4'b0000, 5'd16, 1'b1, 2'd2},  // 11 R8 tally 32
        {4'b0100, 4'b0000, 5'd16, 1'b1, 2'd2},  // 12 R8 tally 48
        {4'b1100, 4'b0000, 5'd16, 1'b1, 2'd2},  // 13 R8 tally 64 -> src3
        {4'b1100, 4'b0000, 5'd16, 1'b1, 2'd3},  // 14 R7 tally 16
        {4'b1000, 4'b0000, 5'd0,  1'b1, 2'd3},  // 15 R5 empty keep
        {4'b1001, 4'b0000, 5'd16, 1'b1, 2'd3},  // 16 R5 tally 32
        {4'b1001, 4'b0000, 5'd16, 1'b1, 2'd3},  // 17 R5 tally 48
        {4'b1001, 4'b0000, 5'd16, 1'b1, 2'd3},  // 18 R7 wrap -> src0
        {4'b0000, 4'b0000, 5'd16, 1'b1, 2'd0},  // 19 R9 nobody requests
        {4'b0100, 4'b0000, 5'd16, 1'b1, 2'd0},  // 20 R9 idle hand-over -> src2
        {4'b0110, 4'b0000, 5'd16, 1'b1, 2'd2},  // 21 R9 tally 16
        {4'b0010, 4'b0000, 5'd16, 1'b1, 2'd2},  // 22 R4 silent, no hand-over
        {4'b0110, 4'b0100, 5'd16, 1'b1, 2'd2},  // 23 R6 last -> src1
        {4'b0010, 4'b0000, 5'd16, 1'b1, 2'd1}   // 24 R7
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N-1:0]      s_tvalid = '0;
    logic [N-1:0]      s_tready;
    logic [N*DW-1:0]   s_tdata;
    logic [N*KW-1:0]   s_tkeep = '0;
    logic [N-1:0]      s_tlast = '0;
    logic [N*6-1:0]    s_tid;
    logic [N*10-1:0]   s_tdest;
    logic              m_tvalid;
    logic              m_tready = 1'b0;
    logic [DW-1:0]     m_tdata;
    logic [KW-1:0]     m_tkeep;
    logic              m_tlast;
    logic [5:0]        m_tid;
    logic [9:0]        m_tdest;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    axis_ilv_arb #(.N(N), .DW(DW)) dut (.*);

    function automatic logic [DW-1:0] pat(int i);
        return {8{16'hA000 + 16'(i)}};
    endfunction

    function automatic string tag_of(int i);
        case (i)
            0:  return "R2 R5";
            1, 2, 21: return "R4";
            3:  return "R3";
            4, 5, 14, 15, 16: return "R5";
            7, 22: return "R6";
            8, 6, 13, 17, 23: return "R7";
            9, 10, 11, 12: return "R8";
            default: return "R9";
        endcase
    endfunction

    initial begin
        for (int i = 0; i < N; i++) begin
            s_tdata[i*DW +: DW] = pat(i);
            s_tid[i*6 +: 6]     = 6'(10 + i);
            s_tdest[i*10 +: 10] = 10'(100 + i);
        end
    end

    task automatic drive(input logic [3:0] v, input logic [3:0] l, input int k, input logic r);
        s_tvalid = v;
        s_tlast  = l;
        m_tready = r;
        for (int i = 0; i < N; i++) s_tkeep[i*KW +: KW] = KW'((32'h1 << k) - 1);
    endtask

    task automatic check_src(input string tag, input int src, input logic r, input int k);
        logic [N-1:0] exp_rdy;
        bit ok;
        exp_rdy = r ? (N'(1) << src) : '0;
        ok = (m_tvalid == s_tvalid[src]) && (m_tdata == pat(src)) &&
             (m_tid == 6'(10 + src)) && (m_tdest == 10'(100 + src)) &&
             (m_tlast == s_tlast[src]) && (m_tkeep == KW'((32'h1 << k) - 1)) &&
             (s_tready == exp_rdy);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: got tid=%0d valid=%0b ready=%b, expected tid=%0d valid=%0b ready=%b",
                     tag, m_tid, m_tvalid, s_tready, 10 + src, s_tvalid[src], exp_rdy);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state, nobody requesting, output ready
        drive(4'b0000, 4'b0000, 16, 1'b1);
        #1 check_src("R1", 0, 1'b1, 16);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][15:12], VEC[i][11:8], int'(VEC[i][7:3]), VEC[i][2]);
            #1 check_src(tag_of(i), int'(VEC[i][1:0]), VEC[i][2], int'(VEC[i][7:3]));
        end

        // R1: reset in the middle of a chunk returns the grant to source 0
        @(negedge clk);
        drive(4'b0010, 4'b0000, 16, 1'b0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        drive(4'b0011, 4'b0000, 16, 1'b0);
        #1 check_src("R1", 0, 1'b0, 16);
        @(negedge clk);
        drive(4'b0011, 4'b0000, 16, 1'b1);
        #1 check_src("R1", 0, 1'b1, 16);

        // R6: a one-byte beat with TLAST hands over immediately
        @(negedge clk);
        drive(4'b0011, 4'b0001, 1, 1'b1);
        #1 check_src("R6", 0, 1'b1, 1);
        @(negedge clk);
        drive(4'b0011, 4'b0000, 1, 1'b1);
        #1 check_src("R6", 1, 1'b1, 1);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            finish_run();
        end
    end

endmodule